// File: doc/BRIEF.md
# Serial ADC Output Interface

This block models the digital side of a three-wire serial converter. An active-low chip select starts each frame. Its falling edge freezes the parallel result word from a stand-in conversion source and starts an internally timed conversion, clocked by the local clock. While the conversion runs, the data line is driven low. When the timer expires, the line goes high to flag that the conversion is done. The host then clocks the result out on falling edges of its serial clock: most significant bit first, then two padding bits, then zeros for as long as the host keeps clocking.

Both serial inputs are asynchronous to the local clock. Each passes through a synchronizer of `SYNC_STAGES` flops before its edges are acted on. There is no valid/ready pair, because the serial side is paced entirely by the host. The block moves to the next bit only on a host clock fall, and it holds the current bit for as long as the host waits. Back-pressure is therefore implicit and unbounded. Raising chip select ends the frame at any point.

Top module: `sadc_serial_port`

## Requirements
- R1: During and right after reset, `sdo_oe`, `busy` and `proto_err` are all 0.
- R2: While chip select is high, `sdo_oe` is 0 (data line released) and `busy` is 0.
- R3: A chip-select fall freezes `sample_in`. From then until the end of conversion, `sdo_oe`=1, `sdo`=0 and `busy`=1. Later changes on `sample_in` do not alter the frame.
- R4: `sdo` rises to 1 and `busy` falls on the (`CONV_CYCLES`+`SYNC_STAGES`)-th rising clock edge after the first edge that samples chip select low. `busy` is high for exactly `CONV_CYCLES` cycles.
- R5: After the end-of-conversion flag, `sdo` changes only in response to a serial clock fall. Rising edges and pauses of any length leave it unchanged.
- R6: Frame order on `sdo`: first the 1 flag, then after falls 1 to 10 the result bits 9 down to 0, then after falls 11 and 12 two bits of 0.
- R7: Every serial clock fall after the twelfth, before chip select rises, gives `sdo`=0.
- R8: Serial clock edges during a conversion do not alter the conversion or the result. They set `proto_err`, which stays 1 until reset.
- R9: A chip-select rise, during conversion or during readout, returns the block to idle. `sdo_oe` is 0 within `SYNC_STAGES`+1 cycles, and no end-of-conversion flag follows.
- R10: The next chip-select fall after an abort starts a fresh conversion with the newly frozen word and the full R4 timing.
- R11: When a chip-select rise and a serial clock fall are seen in the same cycle, the abort wins. The data line is released and `proto_err` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for timer and synchronizers |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sample_in | input | DATA_W | Result word from the conversion stand-in |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the data line (0 = high impedance) |
| busy | output | 1 | High while holding and converting |
| proto_err | output | 1 | Sticky flag: serial clock edge seen during conversion |

## Verification
Two events can land in the same local cycle. One is a chip-select rise meeting a serial clock fall during readout; the other is a stray serial clock edge meeting the conversion timer's last count. The bench provokes the first by dropping the serial clock and raising chip select at the same instant, so both synchronizers report in the same cycle. It judges the result by the released data line, an unchanged error flag and a clean following frame. Stray clock pulses inside the conversion window are judged by the end-of-conversion timing and the frame contents, which must both be unchanged.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } sadc_state_e;
endpackage

// File: rtl/sadc_edge_sync.sv
// Multi-flop synchronizer with edge pulses taken from the settled stage.
module sadc_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sadc_conv_timer.sv
// Conversion timer: done pulses in the last cycle of a run of CONV_CYCLES.
module sadc_conv_timer #(
  parameter int CONV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run && (cnt == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (abort) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_frame_shifter.sv
// Frame register: flag bit, result MSB first, padding, then zero fill.
module sadc_frame_shifter #(
  parameter int DATA_W   = 10,
  parameter int SUB_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [DATA_W-1:0] data,
  output logic              bit_out
);
  localparam int FRAME = 1 + DATA_W + SUB_BITS;

  logic [FRAME-1:0] sh;
  logic [FRAME-1:0] ld_word;

  generate
    if (SUB_BITS > 0) begin : g_pad
      assign ld_word = {1'b1, data, {SUB_BITS{1'b0}}};
    end else begin : g_nopad
      assign ld_word = {1'b1, data};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh <= '0;
    end else if (load) begin
      sh <= ld_word;
    end else if (shift) begin
      sh <= {sh[FRAME-2:0], 1'b0};
    end
  end

  assign bit_out = sh[FRAME-1];
endmodule

// File: rtl/sadc_serial_port.sv
module sadc_serial_port #(
  parameter int DATA_W      = 10,
  parameter int SUB_BITS    = 2,
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              proto_err
);
  import sadc_pkg::*;

  localparam int          N_IN   = 2;
  localparam logic [1:0]  IN_RST = 2'b01;  // index 0 chip select idles high

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_v;
  logic [N_IN-1:0] fall_v;

  assign raw_in = {sclk, cs_n};

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_sync
      sadc_edge_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_RST[i])
      ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[i]),
        .rise (rise_v[i]),
        .fall (fall_v[i])
      );
    end
  endgenerate

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  assign cs_rise   = rise_v[0];
  assign cs_fall   = fall_v[0];
  assign sclk_rise = rise_v[1];
  assign sclk_fall = fall_v[1];

  sadc_state_e       st;
  logic [DATA_W-1:0] samp_q;
  logic              conv_done;
  logic              sh_bit;
  logic              start_conv;

  assign start_conv = (st == ST_IDLE) && cs_fall;

  sadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start_conv),
    .abort(cs_rise),
    .done (conv_done)
  );

  sadc_frame_shifter #(.DATA_W(DATA_W), .SUB_BITS(SUB_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (conv_done && (st == ST_CONV) && !cs_rise),
    .shift  ((st == ST_SHIFT) && sclk_fall && !cs_rise),
    .clear  (cs_rise),
    .data   (samp_q),
    .bit_out(sh_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      samp_q <= '0;
    end else if (cs_rise) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (cs_fall) begin
          st     <= ST_CONV;
          samp_q <= sample_in;
        end
        ST_CONV:  if (conv_done) st <= ST_SHIFT;
        ST_SHIFT: st <= ST_SHIFT;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto_err <= 1'b0;
    end else if ((st == ST_CONV) && !cs_rise && (sclk_rise || sclk_fall)) begin
      proto_err <= 1'b1;
    end
  end

  assign sdo_oe = (st != ST_IDLE);
  assign busy   = (st == ST_CONV);
  assign sdo    = (st == ST_SHIFT) && sh_bit;
endmodule

// File: rtl/sadc_serial_port_chk.sv
module sadc_serial_port_chk #(
  parameter int CONV_CYCLES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sdo,
  input logic                  sdo_oe,
  input logic                  busy,
  input logic                  proto_err,
  input logic                  cs_rise,
  input logic                  sclk_fall,
  input sadc_pkg::sadc_state_e st
);
  import sadc_pkg::*;

  localparam int CW = $clog2(CONV_CYCLES + 2);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sdo_oe && !busy && !proto_err));

  p_conv_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sdo_oe && !sdo));

  p_conv_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && sdo_oe) |-> (bcnt == CW'(CONV_CYCLES)));

  p_hold_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SHIFT) && ($past(st) == ST_SHIFT) && !$past(sclk_fall)) |-> $stable(sdo));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);
endmodule

bind sadc_serial_port sadc_serial_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .busy     (busy),
  .proto_err(proto_err),
  .cs_rise  (cs_rise),
  .sclk_fall(sclk_fall),
  .st       (st)
);

// File: tb/sadc_serial_port_tb.sv
`timescale 1ns/1ps
module sadc_serial_port_tb;
  localparam int W = 10;
  localparam int N = 64;
  localparam int S = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n;
  logic         sclk;
  logic [W-1:0] sample_in;
  logic         sdo, sdo_oe, busy, proto_err;

  always #2.5 clk = ~clk;

  sadc_serial_port #(.DATA_W(W), .SUB_BITS(2), .CONV_CYCLES(N), .SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .proto_err(proto_err)
  );

  typedef struct { logic val; string tag; } exp_t;
  exp_t exp_q[$];
  event smp_ev;
  int   n_run = 0;
  int   n_fail = 0;
  bit   ended = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compare the line against the next expected bit.
  always @(smp_ev) begin
    if (exp_q.size() == 0) begin
      check("R6 unexpected sample", 32'd1, 32'd0);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, e.val});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input logic v, input string tag);
    exp_q.push_back('{val: v, tag: tag});
    -> smp_ev;
    tick(1);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; tick(6);
    sclk = 1'b0; tick(6);
  endtask

  task automatic start_conv(input logic [W-1:0] w, input bit timed);
    @(negedge clk);
    sample_in = w;
    cs_n = 1'b0;
    if (timed) begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R3 oe during conversion", {31'd0, sdo_oe}, 32'd1);
      check("R3 sdo low during conversion", {31'd0, sdo}, 32'd0);
      check("R3 busy during conversion", {31'd0, busy}, 32'd1);
      sample_in = ~w;                       // must not reach the frame (R3)
      repeat (N + S - 4) @(posedge clk);
      @(negedge clk);
      check("R4 no flag one cycle early", {31'd0, sdo}, 32'd0);
      @(negedge clk);
      check("R4 flag on time", {31'd0, sdo}, 32'd1);
      check("R4 busy falls with flag", {31'd0, busy}, 32'd0);
    end else begin
      tick(N + S + 4);
    end
  endtask

  task automatic read_frame(input logic [W-1:0] w, input int extras, input bit hold_test);
    expect_bit(1'b1, "R6 end-of-conversion flag");
    for (int i = W - 1; i >= 0; i--) begin
      pulse_sclk();
      expect_bit(w[i], "R6 data bit");
      if (hold_test && i == 5) begin
        tick(30);
        expect_bit(w[i], "R5 held across low pause");
        sclk = 1'b1;
        tick(30);
        expect_bit(w[i], "R5 held across rising edge");
      end
    end
    for (int k = 0; k < 2; k++) begin
      pulse_sclk();
      expect_bit(1'b0, "R6 padding bit");
    end
    for (int k = 0; k < extras; k++) begin
      pulse_sclk();
      expect_bit(1'b0, "R7 trailing zero");
    end
  endtask

  task automatic end_frame(input string tag);
    @(negedge clk);
    cs_n = 1'b1;
    tick(S + 2);
    check(tag, {30'd0, sdo_oe, busy}, 32'd0);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample_in = '0;
    tick(4);
    check("R1 reset outputs", {29'd0, sdo_oe, busy, proto_err}, 32'd0);
    rst_n = 1'b1;
    tick(1);
    check("R1 outputs right after reset", {29'd0, sdo_oe, busy, proto_err}, 32'd0);
    tick(4);
    check("R2 idle with chip select high", {30'd0, sdo_oe, busy}, 32'd0);

    // Main frame with hold test and trailing zeros
    start_conv(10'h2A5, 1'b1);
    read_frame(10'h2A5, 3, 1'b1);
    end_frame("R2 released after chip select rise");

    // Distinct patterns
    start_conv(10'h3FF, 1'b1); read_frame(10'h3FF, 1, 1'b0); end_frame("R9 release");
    start_conv(10'h000, 1'b1); read_frame(10'h000, 0, 1'b0); end_frame("R9 release");
    start_conv(10'h001, 1'b0); read_frame(10'h001, 2, 1'b0); end_frame("R9 release");
    check("R8 no error from clean frames", {31'd0, proto_err}, 32'd0);

    // Abort during conversion
    @(negedge clk); sample_in = 10'h155; cs_n = 1'b0;
    tick(20);
    cs_n = 1'b1;
    tick(S + 2);
    check("R9 abort in conversion", {30'd0, sdo_oe, busy}, 32'd0);
    tick(N + 10);
    check("R9 no flag after abort", {30'd0, sdo_oe, sdo}, 32'd0);

    // Fresh conversion after abort
    start_conv(10'h0F3, 1'b1); read_frame(10'h0F3, 0, 1'b0); end_frame("R10 release");

    // Abort mid-readout, then restart
    start_conv(10'h2C4, 1'b0);
    expect_bit(1'b1, "R6 end-of-conversion flag");
    for (int i = W - 1; i >= W - 4; i--) begin
      pulse_sclk();
      expect_bit(10'h2C4 >> i, "R6 data bit");
    end
    end_frame("R9 abort in readout");
    start_conv(10'h19A, 1'b1); read_frame(10'h19A, 0, 1'b0); end_frame("R10 release");

    // Chip select rise and serial clock fall in the same instant
    start_conv(10'h366, 1'b0);
    expect_bit(1'b1, "R6 end-of-conversion flag");
    for (int i = W - 1; i >= W - 3; i--) begin
      pulse_sclk();
      expect_bit(10'h366 >> i, "R6 data bit");
    end
    sclk = 1'b1; tick(6);
    @(negedge clk); cs_n = 1'b1; sclk = 1'b0;
    tick(S + 2);
    check("R11 abort wins over clock fall", {30'd0, sdo_oe, busy}, 32'd0);
    check("R11 no error flag", {31'd0, proto_err}, 32'd0);
    start_conv(10'h2B9, 1'b1); read_frame(10'h2B9, 1, 1'b0); end_frame("R11 clean next frame");

    // Serial clock activity during conversion
    @(negedge clk); sample_in = 10'h1C7; cs_n = 1'b0;
    tick(10);
    sclk = 1'b1; tick(6);
    sclk = 1'b0; tick(6);
    check("R8 error flag set", {31'd0, proto_err}, 32'd1);
    check("R8 conversion still running", {31'd0, busy}, 32'd1);
    tick(N);
    read_frame(10'h1C7, 1, 1'b0);
    end_frame("R9 release");
    check("R8 error flag sticky", {31'd0, proto_err}, 32'd1);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
    check("R8 error cleared by reset", {31'd0, proto_err}, 32'd0);

    check("R6 scoreboard drained", exp_q.size(), 32'd0);
    finish_up();
  end
endmodule